// File: doc/BRIEF.md
# Power-Up and Wake Reset Sequencer

This block decides when the processor core may run. It keeps the internal chip reset asserted after power comes up, while the external active-low reset pin is held low, and for a short time after a watchdog timeout. It also stalls the core after an interrupt wakes it from sleep. Two delay counters govern release. The power-up delay counts ticks of a slow on-chip RC oscillator, and it runs only after a power-on. The oscillator settle delay counts main-clock cycles, and it runs only when the oscillator is a crystal and the event is a power-on or an exit from sleep. When both counters are needed, release waits for the longer of the two.

After each event the block records a two-bit status code. Software reads it to learn which of the four kinds of restart took place. The block also tells the core where to continue: at address zero, at the instruction after the sleep, or at the interrupt vector. The master-clear, watchdog, sleep and wake inputs are synchronous to the main clock, and so is the RC tick, which is a one-cycle strobe. The power-on input is asynchronous. Chip reset and wake hold are both released on a main-clock edge.

Top module: `rst_seq_top`

## Requirements
- R1: While por_n is low, chip_rst is 1 and wake_hold is 0. The status pair {stat_nowdt, stat_awake} reads 2'b11 and start_sel reads 0. Power-on leaves these values in place when it ends.
- R2: After power-on, counting begins on the first clock edge that sees ext_rst_n high. chip_rst falls on the clock edge after both enabled delays have expired. The number of sampled cycles with chip_rst high, counted from the cycle in which por_n rises, is max(OST_CYCLES if crystal, PWRT_TICKS) + 2 when rc_tick is held high.
- R3: The oscillator settle delay of OST_CYCLES main clocks applies only for osc_mode 2'b00 or 2'b01 (crystal). osc_mode 2'b10 (external clock) and 2'b11 (RC) never add it.
- R4: The power-up delay advances only on clock edges where rc_tick is 1, and only during a power-up sequence. With no ticks, chip_rst stays high. From the cycle in which ticks start, chip_rst stays high for PWRT_TICKS + 1 sampled cycles.
- R5: ext_rst_n low asserts chip_rst on the next edge and holds it. Counting restarts from zero. The status becomes 2'b11 if the core was running and 2'b10 if it was asleep. After ext_rst_n rises, chip_rst stays high for 2 sampled cycles, or OST_CYCLES + 2 when the core was asleep with a crystal.
- R6: A watchdog timeout while the core is running gives status 2'b01, start_sel 0 and a one-cycle chip_rst.
- R7: A watchdog timeout during sleep gives status 2'b00 and start_sel 0. chip_rst is held for OST_CYCLES + 1 cycles with a crystal and for 1 cycle otherwise.
- R8: An interrupt wake during sleep gives status 2'b10 without asserting chip_rst. start_sel becomes 1 (next instruction) when irq_masked is 1, and 2 (interrupt vector) otherwise. With a crystal, wake_hold is high for OST_CYCLES + 1 cycles. Otherwise it never rises.
- R9: irq_wake with sleep_i low has no effect. Watchdog and wake inputs have no effect while chip_rst or wake_hold is high.
- R10: Whenever chip_rst is high, start_sel is 0. The encoding of start_sel is 0 for address zero, 1 for the next instruction and 2 for the interrupt vector.
- R11: A watchdog timeout and an interrupt wake in the same cycle are treated as the watchdog event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External master reset pin, active low |
| wdt_to | input | 1 | Watchdog timeout strobe |
| sleep_i | input | 1 | Core is in sleep |
| irq_wake | input | 1 | Interrupt wake strobe |
| irq_masked | input | 1 | Global interrupts disabled |
| osc_mode | input | 2 | 00/01 crystal, 10 external clock, 11 RC |
| rc_tick | input | 1 | Slow RC oscillator tick strobe |
| chip_rst | output | 1 | Internal chip reset, active high |
| wake_hold | output | 1 | Core stall during wake settle |
| stat_nowdt | output | 1 | Status bit: 0 after a watchdog reset |
| stat_awake | output | 1 | Status bit: 0 for events during sleep |
| start_sel | output | 2 | Restart point: 0 zero, 1 next, 2 vector |

## Verification
The bench builds the block with OST_CYCLES = 40, PWRT_TICKS = 12 and no extra synchronizer stages on the reset pin. With these values every hold window fits in a few dozen cycles, so each one can be counted exactly. Because the two delays differ, it is visible which delay wins for crystal and non-crystal modes. Holding rc_tick low shows that power-up release depends on the RC ticks alone. The direct reset-pin path keeps all edge positions predictable. Random events, sleep states, modes and mask settings are mixed with directed cases for same-cycle events and for events that arrive during a hold.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   typedef enum logic [1:0] {
      SQ_HOLD  = 2'd0,
      SQ_COUNT = 2'd1,
      SQ_WAKE  = 2'd2,
      SQ_RUN   = 2'd3
   } seq_state_e;

   localparam logic [1:0] START_ZERO = 2'd0;
   localparam logic [1:0] START_NEXT = 2'd1;
   localparam logic [1:0] START_IRQ  = 2'd2;

   localparam logic [1:0] OSC_XTAL_LO = 2'b00;
   localparam logic [1:0] OSC_XTAL_HI = 2'b01;
   localparam logic [1:0] OSC_EXT     = 2'b10;
   localparam logic [1:0] OSC_RC      = 2'b11;

   // status pair {nowdt, awake}
   localparam logic [1:0] CODE_COLD      = 2'b11;
   localparam logic [1:0] CODE_SLEEP     = 2'b10;
   localparam logic [1:0] CODE_WDT_RUN   = 2'b01;
   localparam logic [1:0] CODE_WDT_SLEEP = 2'b00;

   function automatic logic is_crystal(input logic [1:0] mode);
      return (mode == OSC_XTAL_LO) || (mode == OSC_XTAL_HI);
   endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         logic unused_sync;
         assign unused_sync = clk ^ arst_n;
         assign q = d;
      end else begin : g_sync
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) sh_q <= '0;
            else         sh_q <= (sh_q << 1) | STAGES'(d);
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rst_dly_cnt.sv
module rst_dly_cnt #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clr,
   input  logic step,
   output logic done
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                  cnt_q <= '0;
      else if (clr)                 cnt_q <= '0;
      else if (step && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == LIM);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rst_seq_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  logic       ext_ok,
   input  logic       wdt_to,
   input  logic       irq_wake,
   input  logic       sleep_i,
   input  logic       irq_masked,
   input  logic       xtal,
   input  logic       rc_tick,
   input  logic       ost_done,
   input  logic       pwrt_done,
   output seq_state_e state,
   output logic [1:0] code,
   output logic [1:0] sel,
   output logic       cnt_clr,
   output logic       ost_step,
   output logic       pwrt_step
);
   seq_state_e state_q, state_d;
   logic [1:0] code_q, code_d, sel_q, sel_d;
   logic       pwrt_req_q, pwrt_req_d, ost_req_q, ost_req_d;
   logic       ost_ok, pwrt_ok;

   assign ost_ok  = !(ost_req_q && xtal) || ost_done;
   assign pwrt_ok = !pwrt_req_q || pwrt_done;

   always_comb begin
      state_d    = state_q;
      code_d     = code_q;
      sel_d      = sel_q;
      pwrt_req_d = pwrt_req_q;
      ost_req_d  = ost_req_q;
      if (!ext_ok) begin
         state_d = SQ_HOLD;
         if (state_q != SQ_HOLD) begin
            sel_d = START_ZERO;
            if (!pwrt_req_q) begin
               code_d    = sleep_i ? CODE_SLEEP : CODE_COLD;
               ost_req_d = sleep_i;
            end
         end
      end else begin
         unique case (state_q)
            SQ_HOLD: state_d = SQ_COUNT;
            SQ_COUNT: begin
               if (ost_ok && pwrt_ok) begin
                  state_d    = SQ_RUN;
                  pwrt_req_d = 1'b0;
                  ost_req_d  = 1'b0;
               end
            end
            SQ_WAKE: begin
               if (ost_ok) begin
                  state_d   = SQ_RUN;
                  ost_req_d = 1'b0;
               end
            end
            SQ_RUN: begin
               if (wdt_to) begin
                  state_d   = SQ_COUNT;
                  sel_d     = START_ZERO;
                  code_d    = sleep_i ? CODE_WDT_SLEEP : CODE_WDT_RUN;
                  ost_req_d = sleep_i;
               end else if (irq_wake && sleep_i) begin
                  code_d = CODE_SLEEP;
                  sel_d  = irq_masked ? START_NEXT : START_IRQ;
                  if (xtal) begin
                     state_d   = SQ_WAKE;
                     ost_req_d = 1'b1;
                  end
               end
            end
            default: state_d = SQ_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q    <= SQ_HOLD;
         code_q     <= CODE_COLD;
         sel_q      <= START_ZERO;
         pwrt_req_q <= 1'b1;
         ost_req_q  <= 1'b1;
      end else begin
         state_q    <= state_d;
         code_q     <= code_d;
         sel_q      <= sel_d;
         pwrt_req_q <= pwrt_req_d;
         ost_req_q  <= ost_req_d;
      end
   end

   assign state     = state_q;
   assign code      = code_q;
   assign sel       = sel_q;
   assign cnt_clr   = (state_q == SQ_HOLD) || (state_q == SQ_RUN);
   assign ost_step  = (state_q == SQ_COUNT) || (state_q == SQ_WAKE);
   assign pwrt_step = rc_tick && (state_q == SQ_COUNT);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
   import rst_seq_pkg::*;
#(
   parameter int OST_CYCLES  = 1024,
   parameter int PWRT_TICKS  = 1024,
   parameter int EXT_SYNC    = 0
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       ext_rst_n,
   input  logic       wdt_to,
   input  logic       sleep_i,
   input  logic       irq_wake,
   input  logic       irq_masked,
   input  logic [1:0] osc_mode,
   input  logic       rc_tick,
   output logic       chip_rst,
   output logic       wake_hold,
   output logic       stat_nowdt,
   output logic       stat_awake,
   output logic [1:0] start_sel
);
   initial begin
      assert (OST_CYCLES >= 1) else $error("OST_CYCLES must be at least 1");
      assert (PWRT_TICKS >= 1) else $error("PWRT_TICKS must be at least 1");
      assert (EXT_SYNC >= 0 && EXT_SYNC <= 4) else $error("EXT_SYNC out of range");
   end

   logic       ext_ok, xtal;
   logic       cnt_clr, ost_step, pwrt_step, ost_done, pwrt_done;
   logic [1:0] code;
   seq_state_e state;

   assign xtal = is_crystal(osc_mode);

   rst_seq_sync #(.STAGES(EXT_SYNC)) u_sync (
      .clk(clk), .arst_n(por_n), .d(ext_rst_n), .q(ext_ok));

   rst_dly_cnt #(.LIMIT(OST_CYCLES)) u_ost (
      .clk(clk), .arst_n(por_n), .clr(cnt_clr), .step(ost_step), .done(ost_done));

   rst_dly_cnt #(.LIMIT(PWRT_TICKS)) u_pwrt (
      .clk(clk), .arst_n(por_n), .clr(cnt_clr), .step(pwrt_step), .done(pwrt_done));

   rst_seq_ctrl u_ctrl (
      .clk(clk), .arst_n(por_n), .ext_ok(ext_ok), .wdt_to(wdt_to),
      .irq_wake(irq_wake), .sleep_i(sleep_i), .irq_masked(irq_masked),
      .xtal(xtal), .rc_tick(rc_tick), .ost_done(ost_done), .pwrt_done(pwrt_done),
      .state(state), .code(code), .sel(start_sel), .cnt_clr(cnt_clr),
      .ost_step(ost_step), .pwrt_step(pwrt_step));

   assign chip_rst   = (state == SQ_HOLD) || (state == SQ_COUNT);
   assign wake_hold  = (state == SQ_WAKE);
   assign stat_nowdt = code[1];
   assign stat_awake = code[0];
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
   input logic       clk,
   input logic       por_n,
   input logic       ext_ok,
   input logic       wdt_to,
   input logic       irq_wake,
   input logic       sleep_i,
   input logic       irq_masked,
   input logic       xtal,
   input logic       chip_rst,
   input logic       wake_hold,
   input logic       stat_nowdt,
   input logic       stat_awake,
   input logic [1:0] start_sel
);
   logic running;
   assign running = !chip_rst && !wake_hold && ext_ok;

   AST_RELEASE_NEEDS_EXT: assert property (@(posedge clk) disable iff (!por_n)
      $fell(chip_rst) |-> $past(ext_ok)); // R2

   AST_WAKE_NEEDS_XTAL: assert property (@(posedge clk) disable iff (!por_n)
      $rose(wake_hold) |-> $past(xtal)); // R3

   AST_HOLD_ON_EXT: assert property (@(posedge clk) disable iff (!por_n)
      !ext_ok |=> chip_rst); // R5

   AST_WDT_RUN_CODE: assert property (@(posedge clk) disable iff (!por_n)
      (running && wdt_to && !sleep_i) |=> (chip_rst && stat_nowdt == 1'b0 && stat_awake == 1'b1)); // R6

   AST_WDT_SLEEP_CODE: assert property (@(posedge clk) disable iff (!por_n)
      (running && wdt_to && sleep_i) |=> (chip_rst && !stat_nowdt && !stat_awake)); // R7

   AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!por_n)
      (running && !wdt_to && irq_wake && sleep_i) |=>
      (!chip_rst && stat_nowdt && !stat_awake && start_sel == ($past(irq_masked) ? 2'd1 : 2'd2))); // R8

   AST_IGNORE_AWAKE_IRQ: assert property (@(posedge clk) disable iff (!por_n)
      (running && !wdt_to && irq_wake && !sleep_i) |=>
      ($stable(stat_nowdt) && $stable(stat_awake) && $stable(start_sel) && !wake_hold && !chip_rst)); // R9

   AST_VECTOR_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
      chip_rst |-> start_sel == 2'd0); // R10

   AST_WDT_WINS: assert property (@(posedge clk) disable iff (!por_n)
      (running && wdt_to && irq_wake && sleep_i) |=> (chip_rst && !wake_hold)); // R11
endmodule

bind rst_seq_top rst_seq_chk u_chk (
   .clk(clk), .por_n(por_n), .ext_ok(ext_ok), .wdt_to(wdt_to),
   .irq_wake(irq_wake), .sleep_i(sleep_i), .irq_masked(irq_masked),
   .xtal(xtal), .chip_rst(chip_rst), .wake_hold(wake_hold),
   .stat_nowdt(stat_nowdt), .stat_awake(stat_awake), .start_sel(start_sel));

// File: tb/sim_rst_seq_top.sv
module sim_rst_seq_top;
   import rst_seq_pkg::*;

   localparam int OSTN = 40;
   localparam int PWN  = 12;

   logic       clk = 1'b0;
   logic       por_n = 1'b1;
   logic       ext_rst_n = 1'b1;
   logic       wdt_to = 1'b0;
   logic       sleep_i = 1'b0;
   logic       irq_wake = 1'b0;
   logic       irq_masked = 1'b0;
   logic [1:0] osc_mode = OSC_RC;
   logic       rc_tick = 1'b1;
   logic       chip_rst, wake_hold, stat_nowdt, stat_awake;
   logic [1:0] start_sel;

   int errs = 0;
   int checks = 0;

   always #5 clk = ~clk;

   rst_seq_top #(.OST_CYCLES(OSTN), .PWRT_TICKS(PWN), .EXT_SYNC(0)) u0 (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_to(wdt_to),
      .sleep_i(sleep_i), .irq_wake(irq_wake), .irq_masked(irq_masked),
      .osc_mode(osc_mode), .rc_tick(rc_tick), .chip_rst(chip_rst),
      .wake_hold(wake_hold), .stat_nowdt(stat_nowdt), .stat_awake(stat_awake),
      .start_sel(start_sel));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit xt(input logic [1:0] m);
      return (m == 2'b00) || (m == 2'b01);
   endfunction

   function automatic int exp_por(input logic [1:0] m);
      int d;
      d = PWN;
      if (xt(m) && OSTN > d) d = OSTN;
      return d + 2;
   endfunction

   function automatic int status_now();
      return {30'd0, stat_nowdt, stat_awake};
   endfunction

   task automatic meas(input bit use_wake, output int n, output bit other);
      n = 0;
      other = 1'b0;
      while (1'b1) begin
         if (use_wake ? wake_hold : chip_rst) begin
            n++;
            if (use_wake ? chip_rst : wake_hold) other = 1'b1;
         end else break;
         if (n > 2000) break;
         @(negedge clk);
      end
   endtask

   task automatic power_up(input logic [1:0] m);
      int n;
      bit o;
      @(negedge clk);
      por_n = 1'b0; ext_rst_n = 1'b1; sleep_i = 1'b0; osc_mode = m; rc_tick = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 reset in power-on", int'(chip_rst), 1);
      chk("R1 status in power-on", status_now(), 3);
      chk("R1 start_sel in power-on", int'(start_sel), 0);
      por_n = 1'b1;
      meas(1'b0, n, o);
      chk("R2 power-up hold length", n, exp_por(m));
      chk("R1 status after power-up", status_now(), 3);
      chk("R3 no wake hold at power-up", int'(o), 0);
   endtask

   task automatic run_event(input int kind, input bit slp, input logic [1:0] m, input bit msk);
      int n;
      bit o;
      int pst, psel, lo;
      @(negedge clk);
      pst = status_now();
      psel = int'(start_sel);
      sleep_i = slp; osc_mode = m; irq_masked = msk;
      case (kind)
         0: begin
            wdt_to = 1'b1;
            @(negedge clk);
            wdt_to = 1'b0;
            meas(1'b0, n, o);
            if (slp) begin
               chk("R7 wdt sleep hold", n, xt(m) ? OSTN + 1 : 1);
               chk("R7 wdt sleep status", status_now(), 0);
            end else begin
               chk("R6 wdt run hold", n, 1);
               chk("R6 wdt run status", status_now(), 1);
            end
            chk("R10 sel after wdt", int'(start_sel), 0);
         end
         1: begin
            irq_wake = 1'b1;
            @(negedge clk);
            irq_wake = 1'b0;
            if (!slp) begin
               chk("R9 awake irq status", status_now(), pst);
               chk("R9 awake irq sel", int'(start_sel), psel);
               chk("R9 awake irq holds", int'(chip_rst | wake_hold), 0);
            end else begin
               meas(1'b1, n, o);
               chk("R8 wake hold length", n, xt(m) ? OSTN + 1 : 0);
               chk("R8 no chip reset on wake", int'(o | chip_rst), 0);
               chk("R8 wake status", status_now(), 2);
               chk("R8 wake sel", int'(start_sel), msk ? 1 : 2);
            end
         end
         default: begin
            lo = 1 + int'($urandom % 5);
            ext_rst_n = 1'b0;
            @(negedge clk);
            chk("R5 reset follows pin", int'(chip_rst), 1);
            repeat (lo) @(negedge clk);
            ext_rst_n = 1'b1;
            meas(1'b0, n, o);
            chk("R5 pin reset hold", n, (slp && xt(m)) ? OSTN + 2 : 2);
            chk("R5 pin reset status", status_now(), slp ? 2 : 3);
            chk("R10 sel after pin reset", int'(start_sel), 0);
         end
      endcase
      sleep_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int n;
      bit o;
      void'($urandom(32'd7));
      #1 por_n = 1'b0;

      // R2 R3: power-up in each mode
      power_up(OSC_XTAL_HI);
      power_up(OSC_RC);
      power_up(OSC_EXT);
      power_up(OSC_XTAL_LO);

      // R4: power-up delay waits for RC ticks only
      @(negedge clk);
      por_n = 1'b0; osc_mode = OSC_RC; rc_tick = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      repeat (100) @(negedge clk);
      chk("R4 held without ticks", int'(chip_rst), 1);
      rc_tick = 1'b1;
      meas(1'b0, n, o);
      chk("R4 hold after ticks start", n, PWN + 1);

      // R9: watchdog during wake hold is ignored
      @(negedge clk);
      sleep_i = 1'b1; osc_mode = OSC_XTAL_HI; irq_masked = 1'b1; irq_wake = 1'b1;
      @(negedge clk);
      irq_wake = 1'b0;
      repeat (5) @(negedge clk);
      wdt_to = 1'b1;
      @(negedge clk);
      wdt_to = 1'b0;
      chk("R9 wdt ignored in wake hold", int'(chip_rst), 0);
      meas(1'b1, n, o);
      chk("R9 status kept after wake", status_now(), 2);
      chk("R8 masked wake sel", int'(start_sel), 1);
      sleep_i = 1'b0;

      // R11: watchdog and wake in the same cycle
      @(negedge clk);
      sleep_i = 1'b1; osc_mode = OSC_RC; wdt_to = 1'b1; irq_wake = 1'b1;
      @(negedge clk);
      wdt_to = 1'b0; irq_wake = 1'b0;
      chk("R11 wdt wins reset", int'(chip_rst), 1);
      chk("R11 wdt wins no wake", int'(wake_hold), 0);
      meas(1'b0, n, o);
      chk("R11 wdt wins status", status_now(), 0);
      sleep_i = 1'b0;

      // R1: power-on from a resumed state clears sel and status
      run_event(1, 1'b1, OSC_EXT, 1'b0);
      power_up(OSC_EXT);

      for (int i = 0; i < 40; i++) begin
         run_event(int'($urandom % 3), 1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2));
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule